// File: doc/BRIEF.md
# Colour Panel Controller Register Interface

This block is the register front end of a colour LCD panel controller. A host reaches it through a simple 32-bit read/write bus that decodes a 4 KB window. The block holds the panel timing words, the base addresses of the upper and lower panel frames, a control word, an interrupt mask, and a sticky interrupt status. Status bits are cleared by writing ones. A read-only identification area sits at the top of the window. Accesses that fall in the palette window are not decoded here. They are forwarded to a separate palette store, and its read data is returned on the bus.

From the timing words the block derives the active line width in pixels and the active line count, which the pixel fetch and timing logic downstream use. It breaks the control word out into named fields and a single display-enable signal. It also pulses a flag whenever a write changes the derived panel size.

The parameter `VARIANT` selects one of two register maps. The newer map is `VARIANT=1` and the base map is `VARIANT=0`. The two maps differ in where the mask and control words sit and in two of the identification bytes.

Top module: `lcdc_regif`

## Requirements
- R1: After synchronous reset, every stored register reads zero. The outputs are `disp_en=0`, `cols=16` and `rows=1`.
- R2: The words at byte offsets 0x00, 0x04, 0x08 and 0x0C (timing 0 to 3), 0x10 (upper base) and 0x14 (lower base) read back the full 32-bit value last written. Every read returns its data with `bus_rvalid` high one cycle after the request.
- R3: `cols` equals ((timing0 AND 0xFC) + 4) * 4. Only timing0 bits [7:2] affect it.
- R4: `rows` equals (timing1 AND 0x3FF) + 1.
- R5: The control word maps its bits to outputs as follows:
  - bit 0 is enable and bit 11 is power;
  - bits [3:1] drive `bpp_code`;
  - bit 8 drives `bgr_order`;
  - bit 9 drives `be_bytes`;
  - bit 10 drives `be_pixels`.
  `disp_en` is 1 exactly when both bit 0 and bit 11 are 1.
- R6: With `VARIANT=1` the mask sits at offset 0x18 and the control word at 0x1C. With `VARIANT=0` the two are exchanged. The mask holds `IRQ_W` bits and reads zero above them.
- R7: An `irq_set` bit sets the matching status bit, which stays set. Offset 0x20 reads the raw status and 0x24 reads the status ANDed with the mask. A set wins over a clear in the same cycle.
- R8: A write to offset 0x28 clears each status bit where the write data holds a 1 and leaves the other status bits unchanged.
- R9: Offsets 0xFE0 + 4k (k = 0..7) read one identification byte in bits [7:0]. With `VARIANT=1` the bytes are 11 11 24 00 0D F0 05 B1, and with `VARIANT=0` they are 10 11 04 00 0D F0 05 B1.
- R10: For offsets 0x200 to 0x3FF, `pal_sel` is high in the request cycle, with `pal_index` = address bits [8:2] and `pal_wdata` = `bus_wdata`. A read returns `pal_rdata` on the next cycle, and no control register changes.
- R11: Each of the following is an error:
  - a misaligned address;
  - an offset that is not mapped;
  - a write to 0x20, 0x24 or the identification area;
  - a read of 0x28.
  An error access reads zero and changes no register. It raises `bus_err` for the one cycle after the request.
- R12: `geom_chg` is high for the one cycle after a write that changes `cols` or `rows`. It stays low when the written value leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Error response for the previous access |
| irq_set | input | IRQ_W | Interrupt status set strobes |
| pal_sel | output | 1 | Palette window selected |
| pal_write | output | 1 | Palette access is a write |
| pal_index | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data, combinational |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| cols | output | 11 | Active pixels per line |
| rows | output | 11 | Active lines per panel |
| geom_chg | output | 1 | Panel size changed pulse |
| disp_en | output | 1 | Display enabled |
| bpp_code | output | 3 | Bits-per-pixel code |
| bgr_order | output | 1 | Blue/red swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |

## Verification
The assertions take three things for granted:
- `bus_valid` is a clean single-cycle strobe;
- the palette store answers combinationally in the request cycle;
- reset is held from time zero.

The stimulus drives every request at the falling edge, holds it for exactly one cycle and drops it before the next access. It drives `pal_rdata` as a function of `pal_index`, so the forwarded data is always defined. Because the control and geometry outputs change only on writes, the assertions can treat any idle cycle as a point where those outputs are stable.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int PPL_LSB = 2;
    localparam int PPL_W   = 6;
    localparam int LPP_W   = 10;
    localparam int COL_W   = PPL_W + 5;
    localparam int ROW_W   = LPP_W + 1;
    localparam int PAL_W   = 7;
    localparam int PAL_LO  = 128;
    localparam int PAL_HI  = 256;
    localparam int ID_BASE = 1016;

    typedef enum logic [3:0] {
        K_TIM, K_UPB, K_LPB, K_MASK, K_CTRL,
        K_RIS, K_MIS, K_ICR, K_ID, K_PAL, K_BAD
    } reg_kind_e;

    typedef struct packed {
        logic       power;
        logic       be_pix;
        logic       be_byte;
        logic       bgr;
        logic [2:0] bpp;
        logic       en;
    } ctrl_t;

    function automatic reg_kind_e classify(input logic [WORD_W-1:0] w, input int variant);
        reg_kind_e k;
        if (w >= WORD_W'(PAL_LO) && w < WORD_W'(PAL_HI)) k = K_PAL;
        else if (w >= WORD_W'(ID_BASE))                 k = K_ID;
        else begin
            case (w)
                10'd0, 10'd1, 10'd2, 10'd3: k = K_TIM;
                10'd4:  k = K_UPB;
                10'd5:  k = K_LPB;
                10'd6:  k = (variant != 0) ? K_MASK : K_CTRL;
                10'd7:  k = (variant != 0) ? K_CTRL : K_MASK;
                10'd8:  k = K_RIS;
                10'd9:  k = K_MIS;
                10'd10: k = K_ICR;
                default: k = K_BAD;
            endcase
        end
        return k;
    endfunction

    function automatic logic [7:0] id_byte(input int variant, input logic [2:0] idx);
        case (idx)
            3'd0: return (variant != 0) ? 8'h11 : 8'h10;
            3'd1: return 8'h11;
            3'd2: return (variant != 0) ? 8'h24 : 8'h04;
            3'd3: return 8'h00;
            3'd4: return 8'h0D;
            3'd5: return 8'hF0;
            3'd6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] cols_of(input logic [PPL_W-1:0] ppl);
        return {(COL_W-4)'(ppl) + (COL_W-4)'(1), 4'b0000};
    endfunction

    function automatic logic [ROW_W-1:0] rows_of(input logic [LPP_W-1:0] lpp);
        return ROW_W'(lpp) + ROW_W'(1);
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_kind_e         kind,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              bad
);
    logic misaligned;
    logic illegal;

    always_comb begin
        kind       = classify(bus_addr[ADDR_W-1:2], VARIANT);
        misaligned = (bus_addr[1:0] != 2'b00);
        illegal    = misaligned || (kind == K_BAD)
                   || (bus_write && (kind == K_RIS || kind == K_MIS || kind == K_ID))
                   || (!bus_write && kind == K_ICR);
        bad   = bus_valid && illegal;
        wr_ok = bus_valid && bus_write && !illegal;
        rd_ok = bus_valid && !bus_write && !illegal;
    end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PPL_W-1:0] ppl_q,
    input  logic [LPP_W-1:0] lpp_q,
    input  logic             t0_we,
    input  logic             t1_we,
    input  logic [PPL_W-1:0] ppl_new,
    input  logic [LPP_W-1:0] lpp_new,
    output logic [COL_W-1:0] cols,
    output logic [ROW_W-1:0] rows,
    output logic             geom_chg
);
    logic changes;

    always_comb begin
        cols    = cols_of(ppl_q);
        rows    = rows_of(lpp_q);
        changes = (t0_we && cols_of(ppl_new) != cols)
               || (t1_we && rows_of(lpp_new) != rows);
    end

    always_ff @(posedge clk) begin
        if (rst) geom_chg <= 1'b0;
        else     geom_chg <= changes;
    end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] irq_set,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | irq_set;
            if (mask_we) mask <= wdata;
        end
    end
endmodule

// File: rtl/lcdc_regif.sv
module lcdc_regif
    import lcdc_pkg::*;
#(
    parameter int VARIANT = 1,
    parameter int IRQ_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic              pal_sel,
    output logic              pal_write,
    output logic [6:0]        pal_index,
    output logic [31:0]       pal_wdata,
    input  logic [31:0]       pal_rdata,
    output logic [31:0]       upper_base,
    output logic [31:0]       lower_base,
    output logic [10:0]       cols,
    output logic [10:0]       rows,
    output logic              geom_chg,
    output logic              disp_en,
    output logic [2:0]        bpp_code,
    output logic              bgr_order,
    output logic              be_bytes,
    output logic              be_pixels
);
    localparam int NTIM = 4;
    localparam int PADW = DATA_W - IRQ_W;

    reg_kind_e        kind;
    logic             wr_ok, rd_ok, bad;
    logic [31:0]      tim_q [NTIM];
    logic [31:0]      ctrl_q;
    ctrl_t            ctrl_f;
    logic [IRQ_W-1:0] raw, mask;
    logic [1:0]       tidx;
    logic [31:0]      rd_val;

    lcdc_decode #(.VARIANT(VARIANT)) u_dec (
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .kind(kind), .wr_ok(wr_ok), .rd_ok(rd_ok), .bad(bad)
    );

    assign tidx = bus_addr[3:2];

    generate
        for (genvar g = 0; g < NTIM; g++) begin : g_tim
            always_ff @(posedge clk) begin
                if (rst) tim_q[g] <= '0;
                else if (wr_ok && kind == K_TIM && tidx == 2'(g)) tim_q[g] <= bus_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_base <= '0;
            lower_base <= '0;
            ctrl_q     <= '0;
        end else if (wr_ok) begin
            if (kind == K_UPB)  upper_base <= bus_wdata;
            if (kind == K_LPB)  lower_base <= bus_wdata;
            if (kind == K_CTRL) ctrl_q     <= bus_wdata;
        end
    end

    lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk(clk), .rst(rst), .irq_set(irq_set),
        .mask_we(wr_ok && kind == K_MASK), .clr_we(wr_ok && kind == K_ICR),
        .wdata(bus_wdata[IRQ_W-1:0]), .raw(raw), .mask(mask)
    );

    lcdc_geom u_geom (
        .clk(clk), .rst(rst),
        .ppl_q(tim_q[0][PPL_LSB +: PPL_W]), .lpp_q(tim_q[1][LPP_W-1:0]),
        .t0_we(wr_ok && kind == K_TIM && tidx == 2'd0),
        .t1_we(wr_ok && kind == K_TIM && tidx == 2'd1),
        .ppl_new(bus_wdata[PPL_LSB +: PPL_W]), .lpp_new(bus_wdata[LPP_W-1:0]),
        .cols(cols), .rows(rows), .geom_chg(geom_chg)
    );

    always_comb begin
        ctrl_f = '{power: ctrl_q[11], be_pix: ctrl_q[10], be_byte: ctrl_q[9],
                   bgr: ctrl_q[8], bpp: ctrl_q[3:1], en: ctrl_q[0]};
        disp_en   = ctrl_f.en && ctrl_f.power;
        bpp_code  = ctrl_f.bpp;
        bgr_order = ctrl_f.bgr;
        be_bytes  = ctrl_f.be_byte;
        be_pixels = ctrl_f.be_pix;
    end

    assign pal_sel   = bus_valid && kind == K_PAL && !bad;
    assign pal_write = bus_write;
    assign pal_index = bus_addr[8:2];
    assign pal_wdata = bus_wdata;

    always_comb begin
        case (kind)
            K_TIM:   rd_val = tim_q[tidx];
            K_UPB:   rd_val = upper_base;
            K_LPB:   rd_val = lower_base;
            K_MASK:  rd_val = {{PADW{1'b0}}, mask};
            K_CTRL:  rd_val = ctrl_q;
            K_RIS:   rd_val = {{PADW{1'b0}}, raw};
            K_MIS:   rd_val = {{PADW{1'b0}}, raw & mask};
            K_ID:    rd_val = {24'd0, id_byte(VARIANT, bus_addr[4:2])};
            K_PAL:   rd_val = pal_rdata;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
        end else begin
            bus_rdata  <= rd_ok ? rd_val : '0;
            bus_rvalid <= bus_valid && !bus_write;
            bus_err    <= bad;
        end
    end
endmodule

// File: rtl/lcdc_regif_chk.sv
module lcdc_regif_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_write,
    input logic        bus_rvalid,
    input logic        bus_err,
    input logic        pal_sel,
    input logic [10:0] cols,
    input logic [10:0] rows,
    input logic        geom_chg,
    input logic        disp_en,
    input logic [2:0]  bpp_code
);
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);                            // R2
    AST_COLS_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (cols[3:0] == 4'd0) && (cols != 11'd0));                               // R3
    AST_ROWS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rows != 11'd0);                                                         // R4
    AST_CTRL_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> ($stable(disp_en) && $stable(bpp_code)));                // R5
    AST_PAL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        pal_sel |-> bus_valid);                                                 // R10
    AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_valid));                                          // R11
    AST_GEOM_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        geom_chg |-> $past(bus_valid && bus_write));                            // R12
    AST_GEOM_REAL_CHANGE: assert property (@(posedge clk) disable iff (rst)
        geom_chg |-> (cols != $past(cols) || rows != $past(rows)));             // R12
endmodule

bind lcdc_regif lcdc_regif_chk chk_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .pal_sel(pal_sel),
    .cols(cols), .rows(rows), .geom_chg(geom_chg),
    .disp_en(disp_en), .bpp_code(bpp_code)
);

// File: tb/lcdc_regif_tb_top.sv
`timescale 1ns/1ps
module lcdc_regif_tb_top;
    localparam int IRQ_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bv = 1'b0, bw = 1'b0;
    logic [11:0] ba = '0;
    logic [31:0] bd = '0;
    logic [IRQ_W-1:0] iset = '0;

    logic [31:0] rd_i, rd_b, pwd_i, pwd_b, pr_i, pr_b, ub_i, ub_b, lb_i, lb_b;
    logic rv_i, rv_b, er_i, er_b, ps_i, ps_b, pw_i, pw_b;
    logic [6:0] pidx_i, pidx_b;
    logic [10:0] c_i, c_b, r_i, r_b;
    logic g_i, g_b, de_i, de_b, bg_i, bg_b, bb_i, bb_b, bp_i, bp_b;
    logic [2:0] bpp_i, bpp_b;

    int nchk = 0, nfail = 0;
    logic sel_seen;
    logic [6:0] idx_seen;

    always #2 clk = ~clk;

    assign pr_i = 32'hCA00_0000 | 32'(pidx_i);
    assign pr_b = 32'hCB00_0000 | 32'(pidx_b);

    lcdc_regif #(.VARIANT(1), .IRQ_W(IRQ_W)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bv), .bus_write(bw), .bus_addr(ba), .bus_wdata(bd),
        .bus_rdata(rd_i), .bus_rvalid(rv_i), .bus_err(er_i), .irq_set(iset),
        .pal_sel(ps_i), .pal_write(pw_i), .pal_index(pidx_i), .pal_wdata(pwd_i), .pal_rdata(pr_i),
        .upper_base(ub_i), .lower_base(lb_i), .cols(c_i), .rows(r_i), .geom_chg(g_i),
        .disp_en(de_i), .bpp_code(bpp_i), .bgr_order(bg_i), .be_bytes(bb_i), .be_pixels(bp_i));

    lcdc_regif #(.VARIANT(0), .IRQ_W(IRQ_W)) dut_b (
        .clk(clk), .rst(rst), .bus_valid(bv), .bus_write(bw), .bus_addr(ba), .bus_wdata(bd),
        .bus_rdata(rd_b), .bus_rvalid(rv_b), .bus_err(er_b), .irq_set(iset),
        .pal_sel(ps_b), .pal_write(pw_b), .pal_index(pidx_b), .pal_wdata(pwd_b), .pal_rdata(pr_b),
        .upper_base(ub_b), .lower_base(lb_b), .cols(c_b), .rows(r_b), .geom_chg(g_b),
        .disp_en(de_b), .bpp_code(bpp_b), .bgr_order(bg_b), .be_bytes(bb_b), .be_pixels(bp_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive at a falling edge, hold one cycle, results visible at the next falling edge.
    task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bv = 1'b1; bw = w; ba = a; bd = d;
        #1;
        sel_seen = ps_i;
        idx_seen = pidx_i;
        @(negedge clk);
        bv = 1'b0;
    endtask

    task automatic pulse_irq(input logic [IRQ_W-1:0] s);
        @(negedge clk);
        iset = s;
        @(negedge clk);
        iset = '0;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk("R1 cols", 32'(c_i), 32'd16);
        chk("R1 rows", 32'(r_i), 32'd1);
        chk("R1 disp_en", 32'(de_i), 32'd0);
        for (int w = 0; w < 10; w++) begin
            acc(1'b0, 12'(w * 4), '0);
            chk("R1 read zero", rd_i, 32'd0);
            chk("R1 read zero base", rd_b, 32'd0);
        end

        // R3 and R12: sweep every low byte of timing0
        prev = 16;
        for (int b = 0; b < 256; b++) begin
            int exp_c;
            exp_c = ((b & 'hFC) + 4) * 4;
            acc(1'b1, 12'h000, 32'hABCD_0000 | 32'(b));
            chk("R3 cols", 32'(c_i), 32'(exp_c));
            chk("R12 geom_chg t0", 32'(g_i), 32'(exp_c != prev));
            prev = exp_c;
        end
        // R12: same value again gives no pulse
        acc(1'b1, 12'h000, 32'h0000_00FF);
        chk("R12 no change", 32'(g_i), 32'd0);

        // R4 and R12: sweep all line-count values of timing1
        prev = 1;
        for (int v = 0; v < 1024; v++) begin
            int exp_r;
            exp_r = (v & 'h3FF) + 1;
            acc(1'b1, 12'h004, 32'hF000_FC00 | 32'(v));
            chk("R4 rows", 32'(r_i), 32'(exp_r));
            chk("R12 geom_chg t1", 32'(g_i), 32'(exp_r != prev));
            prev = exp_r;
        end

        // R2: read-back of timing and base words
        for (int w = 0; w < 6; w++) begin
            logic [31:0] pat;
            pat = 32'h1357_9BDF ^ (32'(w) * 32'h0101_1111);
            acc(1'b1, 12'(w * 4), pat);
            acc(1'b0, 12'(w * 4), '0);
            chk("R2 readback", rd_i, pat);
            chk("R2 rvalid", 32'(rv_i), 32'd1);
        end
        chk("R2 upper_base", ub_i, 32'h1357_9BDF ^ 32'h0404_4444);
        chk("R2 lower_base", lb_i, 32'h1357_9BDF ^ 32'h0505_5555);

        // R5: control fields (newer map: control at 0x1C)
        acc(1'b1, 12'h01C, 32'h0000_0001);
        chk("R5 enable only", 32'(de_i), 32'd0);
        acc(1'b1, 12'h01C, 32'h0000_0800);
        chk("R5 power only", 32'(de_i), 32'd0);
        acc(1'b1, 12'h01C, 32'h0000_0801);
        chk("R5 both", 32'(de_i), 32'd1);
        acc(1'b1, 12'h01C, 32'h0000_0F0E);
        chk("R5 fields", {27'd0, bp_i, bb_i, bg_i, de_i, 1'b0}, 32'h0000_001C);
        chk("R5 bpp", 32'(bpp_i), 32'd7);
        acc(1'b1, 12'h01C, 32'h0000_0204);
        chk("R5 fields 2", {25'd0, bpp_i, bp_i, bb_i, bg_i, de_i}, 32'h0000_0024);

        // R6: swap of mask and control
        chk("R6 base ctrl not at 0x1C", 32'(de_b), 32'd0);
        acc(1'b0, 12'h01C, '0);
        chk("R6 base mask at 0x1C", rd_b, 32'h0000_0004);
        acc(1'b1, 12'h018, 32'h0000_0801);
        chk("R6 base ctrl at 0x18", 32'(de_b), 32'd1);
        acc(1'b0, 12'h018, '0);
        chk("R6 newer mask at 0x18", rd_i, 32'h0000_0001);
        chk("R6 base ctrl read", rd_b, 32'h0000_0801);

        // R7: sticky status, raw and masked reads
        pulse_irq(5'b10101);
        pulse_irq(5'b00010);
        acc(1'b0, 12'h020, '0);
        chk("R7 raw", rd_i, 32'h0000_0017);
        acc(1'b0, 12'h024, '0);
        chk("R7 masked", rd_i, 32'h0000_0001);
        chk("R7 masked base", rd_b, 32'h0000_0004);

        // R8: write-one-to-clear
        acc(1'b1, 12'h028, 32'hFFFF_FF05);
        acc(1'b0, 12'h020, '0);
        chk("R8 clear", rd_i, 32'h0000_0012);

        // R7: set wins over clear in the same cycle
        @(negedge clk);
        bv = 1'b1; bw = 1'b1; ba = 12'h028; bd = 32'h0000_0010; iset = 5'b10000;
        @(negedge clk);
        bv = 1'b0; iset = '0;
        acc(1'b0, 12'h020, '0);
        chk("R7 set wins", rd_i, 32'h0000_0012);

        // R9: identification bytes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] en, eb;
            case (k)
                0: begin en = 8'h11; eb = 8'h10; end
                1: begin en = 8'h11; eb = 8'h11; end
                2: begin en = 8'h24; eb = 8'h04; end
                3: begin en = 8'h00; eb = 8'h00; end
                4: begin en = 8'h0D; eb = 8'h0D; end
                5: begin en = 8'hF0; eb = 8'hF0; end
                6: begin en = 8'h05; eb = 8'h05; end
                default: begin en = 8'hB1; eb = 8'hB1; end
            endcase
            acc(1'b0, 12'(12'hFE0 + k * 4), '0);
            chk("R9 id newer", rd_i, 32'(en));
            chk("R9 id base", rd_b, 32'(eb));
        end

        // R10: palette window forwarding
        for (int p = 0; p < 128; p += 37) begin
            acc(1'b1, 12'(12'h200 + p * 4), 32'hDEAD_0000);
            chk("R10 pal_sel", 32'(sel_seen), 32'd1);
            chk("R10 pal_index", 32'(idx_seen), 32'(p));
            acc(1'b0, 12'(12'h200 + p * 4), '0);
            chk("R10 pal read", rd_i, 32'hCA00_0000 | 32'(p));
        end
        acc(1'b0, 12'h014, '0);
        chk("R10 regs untouched", rd_i, 32'h1357_9BDF ^ 32'h0505_5555);
        acc(1'b0, 12'h000, '0);
        chk("R10 no pal_sel outside", 32'(sel_seen), 32'd0);

        // R11: errors
        acc(1'b0, 12'h02C, '0);
        chk("R11 undef read err", 32'(er_i), 32'd1);
        chk("R11 undef read zero", rd_i, 32'd0);
        @(negedge clk);
        chk("R11 err one cycle", 32'(er_i), 32'd0);
        acc(1'b1, 12'h010 | 12'h002, 32'hFFFF_FFFF);
        chk("R11 misaligned err", 32'(er_i), 32'd1);
        chk("R11 misaligned ignored", ub_i, 32'h1357_9BDF ^ 32'h0404_4444);
        acc(1'b1, 12'h020, 32'h0);
        chk("R11 write raw err", 32'(er_i), 32'd1);
        acc(1'b0, 12'h020, '0);
        chk("R11 raw unchanged", rd_i, 32'h0000_0012);
        acc(1'b1, 12'hFE0, 32'h0);
        chk("R11 id write err", 32'(er_i), 32'd1);
        acc(1'b0, 12'h028, '0);
        chk("R11 icr read err", 32'(er_i), 32'd1);
        acc(1'b0, 12'h000, '0);
        chk("R11 good read no err", 32'(er_i), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule